// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in memory. A translation request starts each walk, typically after a TLB miss. The walker captures the address, the request kind (load or store) and the current process's root pointer. The root pointer gives the physical base of the top-level directory.

The walker reads one 32-bit word from the directory and, if that slot is populated, one word from the second-level table. It then reports either a physical address with the leaf's attribute byte, or a fault with a cause code and the faulting virtual address. When a store walks to a valid leaf whose accessed or dirty flag is clear, the walker can write the leaf back with both flags set before it reports. Only one walk runs at a time.

Memory is reached through a read/write request port with a valid/ready handshake. Read data comes back later on a separate response strobe.

Top module: `pt_walker`

## Requirements
- R1: The directory read address is `{root_base[31:12], vaddr[31:22], 2'b00}`. Bits 11:0 of `root_base` have no effect.
- R2: If bit 0 of the directory word is 0 (empty slot), the walk ends with `done_fault` = 1. It makes no second-level read and no write.
- R3: If the directory word has bit 0 set, the leaf read address is `{dir[31:12], vaddr[21:12], 2'b00}`. Directory bits 11:1 are ignored.
- R4: A leaf with bit 0 set gives `done_fault` = 0 and `done_paddr` = `{pte[31:12], vaddr[11:0]}`. It also gives `done_attr` = pte[7:0], with this layout: bit0 valid, bit1 read, bit2 write, bit3 execute, bit4 user, bit5 cacheable, bit6 accessed, bit7 dirty.
- R5: A leaf with bit 0 clear gives `done_fault` = 2 and `done_fault_vaddr` equal to the full request address. `done_paddr` and `done_attr` read zero.
- R6: A walk performs exactly one read per level it visits. A memory request keeps its valid, address and write flag stable until `mem_req_ready` is seen.
- R7: `req_ready` is high only while idle. Asserting `req_valid` during a walk starts nothing and does not change the walk in progress.
- R8: A store request that reaches a valid leaf with bit 6 or bit 7 clear makes exactly one write of `pte | 32'hC0` to the leaf address before completion. The reported `done_attr` shows both flags set.
- R9: A load request, a faulting walk, or a leaf that already has bits 6 and 7 set produces no memory write.
- R10: `done_valid` is a one-cycle pulse per walk. `done_fault_vaddr` reads zero on a successful walk.
- R11: During and right after reset, `req_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| root_base | input | 32 | Physical base of the directory (bits 31:12 used) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_we | output | 1 | Request is a write-back |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| done_valid | output | 1 | Walk result valid (one cycle) |
| done_paddr | output | 32 | Translated physical address |
| done_attr | output | 8 | Leaf attribute byte |
| done_fault | output | 2 | 0 none, 1 empty directory slot, 2 invalid leaf |
| done_fault_vaddr | output | 32 | Virtual address of a faulting walk |

## Verification
The hardest situation to reach is the store write-back while the memory side stalls. The write must follow the leaf read, wait out a withheld ready without its address or data changing, and still land before completion. Random walks draw ready and response latency per cycle, and they mix loads and stores with leaves whose accessed and dirty flags are random. The bench also holds `req_valid` high for a whole walk to show that a busy walker ignores it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int PTE_W  = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int ENT_SH = 2;
    localparam int ATTR_W = 8;
    localparam int FRM_W  = PA_W - OFF_W;
    localparam int DIR_LSB = OFF_W + IDX_W;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_LEAF = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_LEAF_REQ,
        S_LEAF_WAIT,
        S_WB_REQ,
        S_DONE
    } walk_st_e;

    typedef struct packed {
        logic dirty;
        logic accessed;
        logic cacheable;
        logic user;
        logic exec;
        logic write;
        logic read;
        logic valid;
    } pte_attr_t;

    typedef struct packed {
        logic [FRM_W-1:0]          frame;
        logic [OFF_W-ATTR_W-1:0]   spare;
        pte_attr_t                 attr;
    } pte_t;

    function automatic logic [PA_W-1:0] entry_addr(input logic [FRM_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return {base, idx, {ENT_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [FRM_W-1:0] root_frame,
    input  logic [FRM_W-1:0] tbl_frame,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             sel_leaf,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] dir_addr;
    logic [PA_W-1:0] leaf_addr;

    assign dir_addr  = entry_addr(root_frame, vaddr[VA_W-1:DIR_LSB]);
    assign leaf_addr = entry_addr(tbl_frame, vaddr[DIR_LSB-1:OFF_W]);
    assign addr      = sel_leaf ? leaf_addr : dir_addr;

    logic unused_off;
    assign unused_off = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter bit WB_EN = 1'b1
)(
    input  logic [PTE_W-1:0] word,
    input  logic             is_store,
    output logic             present,
    output logic [FRM_W-1:0] frame,
    output logic             need_wb,
    output logic [PTE_W-1:0] updated
);
    pte_t p;
    assign p       = pte_t'(word);
    assign present = p.attr.valid;
    assign frame   = p.frame;

    generate
        if (WB_EN) begin : g_wb
            pte_t u;
            always_comb begin
                u               = p;
                u.attr.accessed = 1'b1;
                u.attr.dirty    = 1'b1;
            end
            assign need_wb = is_store && p.attr.valid &&
                             !(p.attr.accessed && p.attr.dirty);
            assign updated = u;
        end else begin : g_nowb
            assign need_wb = 1'b0;
            assign updated = word;
            logic unused_nowb;
            assign unused_nowb = is_store;
        end
    endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter bit WB_EN = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PA_W-1:0]   root_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic              mem_req_we,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic [ATTR_W-1:0] done_attr,
    output logic [1:0]        done_fault,
    output logic [VA_W-1:0]   done_fault_vaddr
);
    walk_st_e         st_q, st_d;
    logic [VA_W-1:0]  va_q;
    logic             we_q;
    logic [FRM_W-1:0] root_q;
    logic [FRM_W-1:0] tbl_q;
    logic [PTE_W-1:0] leaf_q;
    fault_e           flt_q;

    logic             rsp_present;
    logic             rsp_need_wb;
    logic [FRM_W-1:0] rsp_frame;
    logic [PTE_W-1:0] rsp_updated;

    ptw_pte_decode #(.WB_EN(WB_EN)) u_dec (
        .word     (mem_rsp_data),
        .is_store (we_q),
        .present  (rsp_present),
        .frame    (rsp_frame),
        .need_wb  (rsp_need_wb),
        .updated  (rsp_updated)
    );

    ptw_addr_gen u_ag (
        .root_frame (root_q),
        .tbl_frame  (tbl_q),
        .vaddr      (va_q),
        .sel_leaf   (st_q != S_DIR_REQ),
        .addr       (mem_req_addr)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:      if (req_valid) st_d = S_DIR_REQ;
            S_DIR_REQ:   if (mem_req_ready) st_d = S_DIR_WAIT;
            S_DIR_WAIT:  if (mem_rsp_valid) st_d = rsp_present ? S_LEAF_REQ : S_DONE;
            S_LEAF_REQ:  if (mem_req_ready) st_d = S_LEAF_WAIT;
            S_LEAF_WAIT: if (mem_rsp_valid) st_d = rsp_need_wb ? S_WB_REQ : S_DONE;
            S_WB_REQ:    if (mem_req_ready) st_d = S_DONE;
            S_DONE:      st_d = S_IDLE;
            default:     st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            va_q   <= '0;
            we_q   <= 1'b0;
            root_q <= '0;
            tbl_q  <= '0;
            leaf_q <= '0;
            flt_q  <= FLT_NONE;
        end else begin
            st_q <= st_d;
            case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        we_q   <= req_write;
                        root_q <= root_base[PA_W-1:OFF_W];
                        leaf_q <= '0;
                        flt_q  <= FLT_NONE;
                    end
                end
                S_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rsp_present) flt_q <= FLT_DIR;
                        else              tbl_q <= rsp_frame;
                    end
                end
                S_LEAF_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rsp_present) flt_q <= FLT_LEAF;
                        leaf_q <= rsp_need_wb ? rsp_updated : mem_rsp_data;
                    end
                end
                default: ;
            endcase
        end
    end

    pte_t leaf_pte;
    logic ok_done;
    assign leaf_pte = pte_t'(leaf_q);
    assign ok_done  = done_valid && (flt_q == FLT_NONE);

    assign req_ready        = (st_q == S_IDLE);
    assign mem_req_valid    = (st_q == S_DIR_REQ) || (st_q == S_LEAF_REQ) || (st_q == S_WB_REQ);
    assign mem_req_we       = (st_q == S_WB_REQ);
    assign mem_req_wdata    = mem_req_we ? leaf_q : '0;
    assign done_valid       = (st_q == S_DONE);
    assign done_fault       = done_valid ? flt_q : FLT_NONE;
    assign done_paddr       = ok_done ? {leaf_pte.frame, va_q[OFF_W-1:0]} : '0;
    assign done_attr        = ok_done ? leaf_pte.attr : '0;
    assign done_fault_vaddr = (done_valid && flt_q != FLT_NONE) ? va_q : '0;

    logic unused_root;
    assign unused_root = ^root_base[OFF_W-1:0] ^ ^leaf_pte.spare;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_write,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_req_we,
    input logic            done_valid,
    input logic [PA_W-1:0] done_paddr,
    input logic [1:0]      done_fault,
    input logic [VA_W-1:0] done_fault_vaddr
);
    logic [VA_W-1:0] va_c;
    logic            st_c;
    logic [1:0]      rd_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_c <= '0;
            st_c <= 1'b0;
            rd_c <= '0;
        end else if (req_valid && req_ready) begin
            va_c <= req_vaddr;
            st_c <= req_write;
            rd_c <= '0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_we) begin
            rd_c <= rd_c + 2'd1;
        end
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    p_busy_no_ready_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_dir_fault_one_read_r2: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == FLT_DIR |-> rd_c == 2'd1);

    p_two_reads_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault != FLT_DIR |-> rd_c == 2'd2);

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == FLT_NONE |-> done_paddr[OFF_W-1:0] == va_c[OFF_W-1:0]);

    p_fault_va_r5: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault != FLT_NONE |-> done_fault_vaddr == va_c);

    p_write_only_store_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> st_c);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    logic unused_chk;
    assign unused_chk = ^done_paddr[PA_W-1:OFF_W];
endmodule

bind pt_walker ptw_walker_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_vaddr        (req_vaddr),
    .req_write        (req_write),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr),
    .mem_req_we       (mem_req_we),
    .done_valid       (done_valid),
    .done_paddr       (done_paddr),
    .done_fault       (done_fault),
    .done_fault_vaddr (done_fault_vaddr)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    import ptw_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [7:0]  done_attr;
    logic [1:0]  done_fault;
    logic [31:0] done_fault_vaddr;

    pt_walker #(.WB_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_attr(done_attr),
        .done_fault(done_fault), .done_fault_vaddr(done_fault_vaddr)
    );

    logic [31:0] mem [logic [31:0]];
    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int wr_total = 0;
    logic [31:0] last_wa = '0;
    logic [31:0] last_wd = '0;
    bit rand_ready = 1'b0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder, all activity on the falling edge
    bit          hs_q = 1'b0;
    bit          hs_we = 1'b0;
    logic [31:0] hs_addr = '0;
    logic [31:0] hs_wdata = '0;
    bit          rsp_pend = 1'b0;
    int          rsp_delay = 0;
    logic [31:0] rsp_word = '0;

    always @(negedge clk) begin
        if (rst) begin
            hs_q = 1'b0; rsp_pend = 1'b0;
            mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (hs_q) begin
                if (hs_we) begin
                    mem[hs_addr] = hs_wdata;
                    wr_total++;
                    last_wa = hs_addr;
                    last_wd = hs_wdata;
                end else begin
                    rd_total++;
                    rsp_pend = 1'b1;
                    rsp_word = mem_rd(hs_addr);
                    rsp_delay = rand_ready ? int'($urandom % 3) : 0;
                end
            end
            if (rsp_pend) begin
                if (rsp_delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_word;
                    rsp_pend = 1'b0;
                end else rsp_delay--;
            end
            mem_req_ready = rand_ready ? ($urandom % 2 == 0) : 1'b1;
            hs_q     = mem_req_valid && mem_req_ready;
            hs_we    = mem_req_we;
            hs_addr  = mem_req_addr;
            hs_wdata = mem_req_wdata;
        end
    end

    task automatic setup(input logic [31:0] va, input logic [19:0] rootf, input logic [19:0] tblf,
                         input bit dir_ok, input logic [10:0] dir_junk, input logic [31:0] leafw);
        mem.delete();
        mem[{rootf, va[31:22], 2'b00}] = {tblf, dir_junk, dir_ok};
        mem[{tblf, va[21:12], 2'b00}]  = leafw;
    endtask

    task automatic run_walk(input logic [31:0] va, input bit wr, input logic [31:0] root, input bit poke);
        logic [31:0] dirw, la, lw, exp_pa, exp_wd;
        logic [7:0]  exp_attr;
        logic [1:0]  exp_flt;
        int exp_rd, rd0, wr0, cyc;
        bit exp_wb, seen;
        dirw = mem_rd({root[31:12], va[31:22], 2'b00});
        la   = {dirw[31:12], va[21:12], 2'b00};
        lw   = mem_rd(la);
        exp_wb = 1'b0; exp_pa = '0; exp_attr = '0; exp_wd = lw | 32'hC0;
        if (!dirw[0]) begin
            exp_flt = 2'd1; exp_rd = 1;
        end else if (!lw[0]) begin
            exp_flt = 2'd2; exp_rd = 2;
        end else begin
            exp_flt = 2'd0; exp_rd = 2;
            exp_wb  = wr && !(lw[6] && lw[7]);
            exp_pa  = {lw[31:12], va[11:0]};
            exp_attr = exp_wb ? (lw[7:0] | 8'hC0) : lw[7:0];
        end

        cyc = 0;
        while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
        check(req_ready == 1'b1, "R7 ready while idle", {31'b0, req_ready}, 32'h1);
        rd0 = rd_total; wr0 = wr_total;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; root_base = root;
        @(negedge clk);
        if (poke) begin
            req_vaddr = ~va; req_write = ~wr; root_base = ~root;
            check(req_ready == 1'b0, "R7 ready low while busy", {31'b0, req_ready}, 32'h0);
        end else req_valid = 1'b0;

        seen = 1'b0; cyc = 0;
        while (!seen && cyc < 300) begin
            if (done_valid) seen = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        req_valid = 1'b0;
        check(seen, "R10 done seen", {31'b0, seen}, 32'h1);
        check(done_fault == exp_flt, "R2 R5 fault cause", {30'b0, done_fault}, {30'b0, exp_flt});
        check(done_paddr == exp_pa, "R1 R3 R4 paddr", done_paddr, exp_pa);
        check(done_attr == exp_attr, "R4 R8 attr", {24'b0, done_attr}, {24'b0, exp_attr});
        check(done_fault_vaddr == (exp_flt != 2'd0 ? va : 32'h0), "R5 R10 fault vaddr",
              done_fault_vaddr, (exp_flt != 2'd0 ? va : 32'h0));

        @(negedge clk);
        check(done_valid == 1'b0, "R10 single pulse", {31'b0, done_valid}, 32'h0);
        check(mem_req_valid == 1'b0, "R7 no walk from busy request", {31'b0, mem_req_valid}, 32'h0);
        check(rd_total - rd0 == exp_rd, "R6 R2 read count", rd_total - rd0, exp_rd);
        check(wr_total - wr0 == (exp_wb ? 1 : 0), "R8 R9 write count", wr_total - wr0, exp_wb ? 1 : 0);
        if (exp_wb) begin
            check(last_wa == la, "R8 write addr", last_wa, la);
            check(last_wd == exp_wd, "R8 write data", last_wd, exp_wd);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", n_chk);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] va, lw;
        logic [19:0] rf, tf;
        void'($urandom(32'd7715));
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R11 ready in reset", {31'b0, req_ready}, 32'h1);
        check(mem_req_valid == 1'b0, "R11 no mem req in reset", {31'b0, mem_req_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(done_valid == 1'b0, "R11 no done after reset", {31'b0, done_valid}, 32'h0);
        check(mem_req_valid == 1'b0, "R11 idle after reset", {31'b0, mem_req_valid}, 32'h0);

        // R2 empty directory slot
        va = 32'h1234_5678;
        setup(va, 20'h00100, 20'h00200, 1'b0, 11'h7FF, 32'hCAFE_F0FF);
        run_walk(va, 1'b1, 32'h0010_0000, 1'b0);
        // R5 invalid leaf on a store
        setup(va, 20'h00100, 20'h00200, 1'b1, 11'h000, 32'hCAFE_F0FE);
        run_walk(va, 1'b1, 32'h0010_0000, 1'b0);
        // R4 valid leaf, load: no write (R9)
        va = 32'hFFC0_1ABC;
        setup(va, 20'h00300, 20'h00400, 1'b1, 11'h155, {20'hABCDE, 4'h0, 8'h3F});
        run_walk(va, 1'b0, 32'h0030_0000, 1'b0);
        // R8 store with accessed and dirty clear
        run_walk(va, 1'b1, 32'h0030_0000, 1'b0);
        check(mem_rd({20'h00400, va[21:12], 2'b00}) == {20'hABCDE, 4'h0, 8'hFF}, "R8 leaf updated",
              mem_rd({20'h00400, va[21:12], 2'b00}), {20'hABCDE, 4'h0, 8'hFF});
        // R9 store with both flags already set
        run_walk(va, 1'b1, 32'h0030_0000, 1'b0);
        // R8 store with only accessed set
        va = 32'h0000_0FFF;
        setup(va, 20'h00500, 20'h00600, 1'b1, 11'h0, {20'h00001, 4'h0, 8'h45});
        run_walk(va, 1'b1, 32'h0050_0000, 1'b0);
        // R1 low root bits ignored
        va = 32'h8040_2001;
        setup(va, 20'h12345, 20'h54321, 1'b1, 11'h3AA, {20'hF0F0F, 4'h0, 8'h03});
        run_walk(va, 1'b0, 32'h1234_5ABC, 1'b0);
        // R7 request held high during a walk
        run_walk(va, 1'b0, 32'h1234_5000, 1'b1);

        rand_ready = 1'b1;
        for (int i = 0; i < 60; i++) begin
            va = $urandom;
            rf = 20'($urandom);
            tf = 20'($urandom);
            if (tf == rf) tf = rf ^ 20'h1;
            lw = $urandom;
            lw[0] = ($urandom % 4) != 0;
            setup(va, rf, tf, ($urandom % 4) != 0, 11'($urandom), lw);
            run_walk(va, 1'($urandom), {rf, 12'($urandom)}, (i % 7) == 3);
        end

        summary();
        $finish;
    end
endmodule